// File: doc/BRIEF.md
# Dual-Channel Registered Bus Transceiver

The block links two bidirectional buses, A and B, through a set of independent byte-wide channels. Each channel has a capture register and an output path in each direction. Every rising edge of a direction's clock loads that direction's capture register, whatever the enables and selects are set to. A select bit for each direction chooses whether the opposite bus is driven from the live input or from the register. The enable that drives bus B is active high. The enable that drives bus A is active low.

Each bus has its own input, output and drive-enable ports, so the tri-state pins are resolved outside the block. The input ports carry the resolved bus value. When one side drives live data onto the other bus, a capture on the other direction's clock therefore copies one register's contents into the other. When both directions drive live data, each bus holds its last value.

Top module: `regxcvr`

## Requirements
- R1: The block has CH independent channels, default 2, each W bits wide, default 8. Channel c occupies bits [c*W +: W] of every data port and bit c of every control port. No control of one channel changes the outputs, drive enables or registers of another channel.
- R2: On every rising edge of clk_ab[c], the A register loads a_in. On every rising edge of clk_ba[c], the B register loads b_in. Both loads happen regardless of the enable and select inputs.
- R3: b_drv[c] equals en_ab[c], which is active high. a_drv[c] is the inverse of en_ba_n[c], which is active low. With en_ab=0 and en_ba_n=1, the channel drives neither bus.
- R4: With sel_ab=0, b_out carries the live a_in. With sel_ab=1, b_out carries the A register. sel_ba selects in the same way between the live b_in and the B register for a_out.
- R5: With both directions enabled on live data and no other driver present, each bus keeps its last value, and each output equals that value.
- R6: While bus B is driven live from A, a clk_ba edge loads the A value into the B register. Bus A driven live from B mirrors this for clk_ab. The copy also holds when both clocks rise in the same instant.
- R7: With sel_ab=1 and bus B driven, a clk_ab edge followed later by a clk_ba edge leaves the same new value in both registers.
- R8: With both directions enabled on stored data, b_out shows the A register and a_out shows the B register at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | CH | A-side capture clock, one per channel |
| clk_ba | input | CH | B-side capture clock, one per channel |
| en_ab | input | CH | Active-high enable for driving bus B |
| en_ba_n | input | CH | Active-low enable for driving bus A |
| sel_ab | input | CH | Source for bus B: 0 live A, 1 A register |
| sel_ba | input | CH | Source for bus A: 0 live B, 1 B register |
| a_in | input | CH*W | Resolved value of bus A |
| a_out | output | CH*W | Value offered to bus A |
| a_drv | output | CH | Drive enable for bus A |
| b_in | input | CH*W | Resolved value of bus B |
| b_out | output | CH*W | Value offered to bus B |
| b_drv | output | CH | Drive enable for bus B |

## Verification
The hardest state to reach is the one in which one register copies the other. It needs the bus resolved from the block's own output, so the bench models each bus as the block's output when it drives and as an external source otherwise. A keeper covers the case where both directions drive live data. The register copy is then made with both clocks pulsed together, and also staggered under stored selection. The bench reads the registers back only through the stored-select path. Channel independence is shown by preloading one channel and reading it back after the other channel has gone through every scenario.

// File: rtl/regxcvr.sv
module regxcvr #(
  parameter int CH = 2,
  parameter int W  = 8
) (
  input  logic [CH-1:0]   clk_ab,
  input  logic [CH-1:0]   clk_ba,
  input  logic [CH-1:0]   en_ab,
  input  logic [CH-1:0]   en_ba_n,
  input  logic [CH-1:0]   sel_ab,
  input  logic [CH-1:0]   sel_ba,
  input  logic [CH*W-1:0] a_in,
  output logic [CH*W-1:0] a_out,
  output logic [CH-1:0]   a_drv,
  input  logic [CH*W-1:0] b_in,
  output logic [CH*W-1:0] b_out,
  output logic [CH-1:0]   b_drv
);

  for (genvar g = 0; g < CH; g++) begin : g_ch
    logic [W-1:0] areg, breg;
    logic [W-1:0] a_now, b_now;

    assign a_now = a_in[g*W +: W];
    assign b_now = b_in[g*W +: W];

    always_ff @(posedge clk_ab[g]) areg <= a_now;
    always_ff @(posedge clk_ba[g]) breg <= b_now;

    assign b_out[g*W +: W] = sel_ab[g] ? areg : a_now;
    assign a_out[g*W +: W] = sel_ba[g] ? breg : b_now;
    assign b_drv[g] = en_ab[g];
    assign a_drv[g] = ~en_ba_n[g];

    logic [1:0] ab_seen = 2'd0;
    logic [1:0] ba_seen = 2'd0;
    always_ff @(posedge clk_ab[g]) if (ab_seen != 2'd2) ab_seen <= ab_seen + 2'd1;
    always_ff @(posedge clk_ba[g]) if (ba_seen != 2'd2) ba_seen <= ba_seen + 2'd1;

    // R2
    cap_a_chk: assert property (@(posedge clk_ab[g]) disable iff (ab_seen != 2'd2)
      areg == $past(a_now));
    // R2
    cap_b_chk: assert property (@(posedge clk_ba[g]) disable iff (ba_seen != 2'd2)
      breg == $past(b_now));
    // R6
    copy_ab_chk: assert property (@(posedge clk_ba[g]) disable iff (ba_seen == 2'd0)
      (b_drv[g] && !sel_ab[g]) |=> (breg == $past(a_now)));
    // R6
    copy_ba_chk: assert property (@(posedge clk_ab[g]) disable iff (ab_seen == 2'd0)
      (a_drv[g] && !sel_ba[g]) |=> (areg == $past(b_now)));
    // R3
    always_comb begin
      if (!en_ab[g] && en_ba_n[g]) iso_chk: assert (!a_drv[g] && !b_drv[g]);
    end
  end

endmodule

// File: tb/regxcvr_tb.sv
module regxcvr_tb;
  localparam int CH = 2;
  localparam int W  = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [CH-1:0] clk_ab = '0, clk_ba = '0, en_ab = '0, en_ba_n = '1, sel_ab = '0, sel_ba = '0;
  logic [CH-1:0][W-1:0] ext_a, ext_b, a_bus, b_bus, a_out, b_out;
  logic [W-1:0] keep_a [CH];
  logic [W-1:0] keep_b [CH];
  logic [CH-1:0] a_drv, b_drv;
  int checks = 0, fails = 0, cyc = 0;

  regxcvr #(.CH(CH), .W(W)) u_dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .en_ab(en_ab), .en_ba_n(en_ba_n),
    .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_bus), .a_out(a_out), .a_drv(a_drv),
    .b_in(b_bus), .b_out(b_out), .b_drv(b_drv));

  for (genvar c = 0; c < CH; c++) begin : g_bus
    wire loop_w = a_drv[c] & ~sel_ba[c] & b_drv[c] & ~sel_ab[c];
    assign a_bus[c] = loop_w ? keep_a[c] : (a_drv[c] ? a_out[c] : ext_a[c]);
    assign b_bus[c] = loop_w ? keep_b[c] : (b_drv[c] ? b_out[c] : ext_b[c]);
    always @(a_bus[c]) keep_a[c] = a_bus[c];
    always @(b_bus[c]) keep_b[c] = b_bus[c];
  end

  task automatic check(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ctl(int c, bit eab, bit eban, bit sab, bit sba);
    en_ab[c] = eab; en_ba_n[c] = eban; sel_ab[c] = sab; sel_ba[c] = sba;
    #2;
  endtask

  task automatic pulse(int c, bit do_ab, bit do_ba);
    if (do_ab) clk_ab[c] = 1'b1;
    if (do_ba) clk_ba[c] = 1'b1;
    #4;
    clk_ab[c] = 1'b0; clk_ba[c] = 1'b0;
    #4;
  endtask

  // load both registers from external values while isolated
  task automatic load(int c, logic [W-1:0] va, logic [W-1:0] vb);
    ctl(c, 0, 1, 0, 0);
    ext_a[c] = va; ext_b[c] = vb; #2;
    pulse(c, 1, 1);
  endtask

  // read registers back through the stored paths
  task automatic readback(int c, string tag, logic [W-1:0] ea, logic [W-1:0] eb);
    ctl(c, 1, 0, 1, 1);
    check({tag, " areg"}, b_out[c], ea);
    check({tag, " breg"}, a_out[c], eb);
    ctl(c, 0, 1, 0, 0);
  endtask

  task automatic t_isolate(int c);
    ctl(c, 0, 1, 0, 0);
    ext_a[c] = 8'h3C; ext_b[c] = 8'hC3; #2;
    check("R3 a_drv off", {7'd0, a_drv[c]}, 8'd0);
    check("R3 b_drv off", {7'd0, b_drv[c]}, 8'd0);
    check("R3 bus A external", a_bus[c], 8'h3C);
    ctl(c, 1, 0, 0, 0);
    check("R3 b_drv on", {7'd0, b_drv[c]}, 8'd1);
    check("R3 a_drv on", {7'd0, a_drv[c]}, 8'd1);
    ctl(c, 0, 1, 0, 0);
  endtask

  task automatic t_store(int c);
    load(c, 8'h5A, 8'hA5);
    readback(c, "R2 store", 8'h5A, 8'hA5);
    // R2: capture regardless of controls, here with stored selects and drives
    ctl(c, 1, 1, 1, 0);
    ext_a[c] = 8'h11; #2;
    pulse(c, 1, 0);
    readback(c, "R2 any ctl", 8'h11, 8'hA5);
  endtask

  task automatic t_live(int c);
    ctl(c, 1, 1, 0, 0);
    ext_a[c] = 8'h77; #2;
    check("R4 live A to B", b_bus[c], 8'h77);
    ext_a[c] = 8'h88; #2;
    check("R4 live A to B follows", b_out[c], 8'h88);
    ctl(c, 0, 0, 0, 0);
    ext_b[c] = 8'h99; #2;
    check("R4 live B to A", a_bus[c], 8'h99);
    ctl(c, 0, 1, 0, 0);
  endtask

  task automatic t_keeper(int c);
    ctl(c, 0, 1, 0, 0);
    ext_a[c] = 8'h6E; ext_b[c] = 8'h00; #2;
    ctl(c, 1, 1, 0, 0);
    ctl(c, 1, 0, 0, 0);
    check("R5 hold A", a_bus[c], 8'h6E);
    check("R5 hold B", b_bus[c], 8'h6E);
    check("R5 a_out", a_out[c], 8'h6E);
    check("R5 b_out", b_out[c], 8'h6E);
    ctl(c, 0, 1, 0, 0);
  endtask

  task automatic t_copy(int c);
    load(c, 8'h01, 8'h02);
    ctl(c, 1, 1, 0, 0);
    ext_a[c] = 8'hB4; #2;
    pulse(c, 1, 1);
    readback(c, "R6 copy A", 8'hB4, 8'hB4);
    load(c, 8'h03, 8'h04);
    ctl(c, 0, 0, 0, 0);
    ext_b[c] = 8'h4B; #2;
    pulse(c, 1, 1);
    readback(c, "R6 copy B", 8'h4B, 8'h4B);
  endtask

  task automatic t_stagger(int c);
    load(c, 8'h10, 8'h20);
    ctl(c, 1, 1, 1, 0);
    ext_a[c] = 8'hE7; #2;
    check("R7 old stored on B", b_bus[c], 8'h10);
    pulse(c, 1, 0);
    check("R7 new stored on B", b_bus[c], 8'hE7);
    pulse(c, 0, 1);
    readback(c, "R7 stagger", 8'hE7, 8'hE7);
  endtask

  task automatic t_both_stored(int c);
    load(c, 8'hD1, 8'h2E);
    ctl(c, 1, 0, 1, 1);
    check("R8 B shows areg", b_bus[c], 8'hD1);
    check("R8 A shows breg", a_bus[c], 8'h2E);
    ctl(c, 0, 1, 0, 0);
  endtask

  task automatic run_all(int c);
    t_isolate(c); t_store(c); t_live(c); t_keeper(c);
    t_copy(c); t_stagger(c); t_both_stored(c);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    ext_a = '0; ext_b = '0;
    #3;
    for (int c = 0; c < CH; c++) begin
      check("R3 idle a_drv", {7'd0, a_drv[c]}, 8'd0);
      check("R3 idle b_drv", {7'd0, b_drv[c]}, 8'd0);
    end
    // R1: preload channel 1, exercise channel 0, then confirm channel 1 intact
    load(1, 8'hC7, 8'h7C);
    ctl(1, 0, 1, 0, 0);
    run_all(0);
    check("R1 ch1 a_drv untouched", {7'd0, a_drv[1]}, 8'd0);
    check("R1 ch1 b_drv untouched", {7'd0, b_drv[1]}, 8'd0);
    readback(1, "R1 ch1 intact", 8'hC7, 8'h7C);
    load(0, 8'h96, 8'h69);
    run_all(1);
    readback(0, "R1 ch0 intact", 8'h96, 8'h69);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule